// File: doc/BRIEF.md
# Converter Control and Result Register Block

This block is the digital front end of a shared 10-bit converter that can run as an analog-to-digital or a digital-to-analog converter. It sits on an 8-bit special-function-register bus and holds three byte registers: one control byte and a high/low result pair. It divides the system clock, or passes through an external slow-oscillator tick, to make the converter clock. It runs the start/busy handshake with the analog macro. On completion it captures the 10-bit signed result, formatted into 16 bits, and raises an interrupt flag.

Software starts a conversion by writing the go bit in the control byte. In hardware-trigger mode a trigger pulse starts it instead, and the go bit only reports activity. The analog macro sees a one-cycle start strobe. It returns a done pulse together with the 10-bit result. Entering the interrupt handler produces an acknowledge pulse, and that pulse clears the flag.

Top module: `conv_front`

## Requirements
- R1: Control byte at address D9h, result low byte at DCh, result high byte at DDh. All three read 00h after reset. Any other address reads 00h. Control bit layout: [7] interrupt flag, [6] go/busy, [5] DAC select, [4] enable, [3] left-adjust, [2:0] clock select. Bits 5:0 read back the value written.
- R2: With enable 1, convClkTick pulses once every 2^k system clocks for clock select k = 1..7. For clock select 0 it follows the external rcTick input.
- R3: Writing the control byte with bit 6 = 1 and bit 4 = 1, while idle and outside hardware-trigger mode, sets go/busy and raises convStart for exactly one cycle.
- R4: On a convDone pulse while busy, in a single cycle, both result bytes are loaded, go/busy clears and the interrupt flag sets.
- R5: An irqAck pulse clears the interrupt flag, unless a completion happens in the same cycle, in which case the flag stays set.
- R6: With left-adjust 0 the result is {6 copies of result bit 9, result[9:0]}. With left-adjust 1 it is {result[9:0], 6'b0}. The format is taken from the left-adjust bit at the moment of completion.
- R7: While enable is 0, a go write starts nothing and convClkTick stays 0.
- R8: A go write during a conversion produces no second start. Writing go/busy = 0 does not stop a running conversion.
- R9: With hwTrigMode = 1, software go writes are ignored and an hwTrig pulse starts a conversion (enable 1, idle).
- R10: A clock-select change written during a conversion only reaches the prescaler after that conversion ends.
- R11: Clearing enable during a conversion ends it at once, with go/busy cleared and no interrupt flag.
- R12: dacMode and convEnable outputs follow control bits 5 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sfrAddr | input | 8 | Register bus address |
| sfrWrEn | input | 1 | Register write strobe |
| sfrWrData | input | 8 | Register write data |
| sfrRdData | output | 8 | Register read data, combinational from sfrAddr |
| irqAck | input | 1 | Interrupt acknowledge pulse |
| hwTrigMode | input | 1 | 1 selects hardware-triggered starts |
| hwTrig | input | 1 | Hardware start pulse |
| rcTick | input | 1 | Slow-oscillator tick used by clock select 0 |
| convStart | output | 1 | One-cycle start strobe to the converter |
| convClkTick | output | 1 | Converter clock enable pulse |
| convDone | input | 1 | Completion pulse from the converter |
| convResult | input | 10 | Signed result, valid with convDone |
| dacMode | output | 1 | DAC operation selected |
| convEnable | output | 1 | Converter enabled |
| irqFlag | output | 1 | Completion interrupt flag |

## Verification
A stuck or lost busy state shows up either as a missing completion or as a second convStart within a few cycles of a go write. The bench reads the control byte one cycle after each write to catch this. A wrong format choice or a torn capture shows up in the result bytes on the first read after the done pulse, where the scoreboard compares them against the value it queued. A prescaler that picks up a clock-select change too early or too late changes the tick spacing measured within two tick periods.

// File: rtl/conv_front_pkg.sv
package conv_front_pkg;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic             startStb;
    logic             captureStb;
    logic             leftAdj;
    logic             prescEn;
    logic [SEL_W-1:0] activeSel;
  } ctrlStb_t;
endpackage

// File: rtl/conv_front_ctrl.sv
module conv_front_ctrl
  import conv_front_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWr,
  input  logic [7:0] wrData,
  input  logic       hwTrigMode,
  input  logic       hwTrig,
  input  logic       convDone,
  input  logic       irqAck,
  output logic [7:0] ctrlByte,
  output logic       convStart,
  output ctrlStb_t   stb
);
  logic             irqQ, busyQ, dacQ, enQ, ladjQ, convStartQ;
  logic [SEL_W-1:0] selQ, activeSelQ;
  logic             newEn, swGo, hwGo, goNow, finish, abort;
  logic [SEL_W-1:0] newSel;

  always_comb begin
    newEn  = ctrlWr ? wrData[4] : enQ;
    newSel = ctrlWr ? wrData[SEL_W-1:0] : selQ;
    swGo   = ctrlWr && wrData[6] && wrData[4] && !busyQ && !hwTrigMode;
    hwGo   = hwTrigMode && hwTrig && enQ && !busyQ;
    goNow  = swGo || hwGo;
    abort  = busyQ && !newEn;
    finish = busyQ && convDone && !abort;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqQ <= 1'b0; busyQ <= 1'b0; dacQ <= 1'b0; enQ <= 1'b0;
      ladjQ <= 1'b0; selQ <= '0; activeSelQ <= '0; convStartQ <= 1'b0;
    end else begin
      convStartQ <= goNow;
      if (ctrlWr) begin
        dacQ  <= wrData[5];
        enQ   <= wrData[4];
        ladjQ <= wrData[3];
        selQ  <= wrData[SEL_W-1:0];
      end
      if (goNow) busyQ <= 1'b1;
      else if (finish || abort) busyQ <= 1'b0;
      if (!busyQ) activeSelQ <= newSel;
      if (finish) irqQ <= 1'b1;
      else if (irqAck) irqQ <= 1'b0;
    end
  end

  assign ctrlByte = {irqQ, busyQ, dacQ, enQ, ladjQ, selQ};
  assign convStart = convStartQ;
  assign stb.startStb   = goNow;
  assign stb.captureStb = finish;
  assign stb.leftAdj    = ladjQ;
  assign stb.prescEn    = enQ;
  assign stb.activeSel  = activeSelQ;
endmodule

// File: rtl/conv_front_dp.sv
module conv_front_dp
  import conv_front_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic             rcTick,
  input  logic [RES_W-1:0] convResult,
  output logic             convClkTick,
  output logic [7:0]       dataLo,
  output logic [7:0]       dataHi
);
  localparam int DATA_W = 16;
  localparam int PAD_W  = DATA_W - RES_W;
  localparam int CNT_W  = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cntQ, lim;
  logic [CNT_W:0]   limWide;
  logic [DATA_W-1:0] dataQ;

  always_comb begin
    limWide = ((CNT_W+1)'(1) << stb.activeSel) - (CNT_W+1)'(1);
    lim     = limWide[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || !stb.prescEn || stb.startStb) cntQ <= '0;
    else if (stb.activeSel != '0) cntQ <= (cntQ >= lim) ? '0 : cntQ + 1'b1;
  end

  assign convClkTick = stb.prescEn && !stb.startStb &&
                       ((stb.activeSel == '0) ? rcTick : (cntQ == lim));

  always_ff @(posedge clk) begin
    if (!rstN) dataQ <= '0;
    else if (stb.captureStb)
      dataQ <= stb.leftAdj ? {convResult, {PAD_W{1'b0}}}
                           : {{PAD_W{convResult[RES_W-1]}}, convResult};
  end

  assign dataLo = dataQ[7:0];
  assign dataHi = dataQ[15:8];
endmodule

// File: rtl/conv_front.sv
module conv_front
  import conv_front_pkg::*;
#(
  parameter logic [7:0] ADDR_CTRL = 8'hD9,
  parameter logic [7:0] ADDR_LO   = 8'hDC,
  parameter logic [7:0] ADDR_HI   = 8'hDD,
  parameter int         RES_W     = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       sfrAddr,
  input  logic             sfrWrEn,
  input  logic [7:0]       sfrWrData,
  output logic [7:0]       sfrRdData,
  input  logic             irqAck,
  input  logic             hwTrigMode,
  input  logic             hwTrig,
  input  logic             rcTick,
  output logic             convStart,
  output logic             convClkTick,
  input  logic             convDone,
  input  logic [RES_W-1:0] convResult,
  output logic             dacMode,
  output logic             convEnable,
  output logic             irqFlag
);
  ctrlStb_t   stb;
  logic [7:0] ctrlByte, dataLo, dataHi;
  logic       ctrlWr;

  assign ctrlWr = sfrWrEn && (sfrAddr == ADDR_CTRL);

  conv_front_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .wrData(sfrWrData),
    .hwTrigMode(hwTrigMode), .hwTrig(hwTrig), .convDone(convDone),
    .irqAck(irqAck), .ctrlByte(ctrlByte), .convStart(convStart), .stb(stb)
  );

  conv_front_dp #(.RES_W(RES_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rcTick(rcTick),
    .convResult(convResult), .convClkTick(convClkTick),
    .dataLo(dataLo), .dataHi(dataHi)
  );

  always_comb begin
    case (sfrAddr)
      ADDR_CTRL: sfrRdData = ctrlByte;
      ADDR_LO:   sfrRdData = dataLo;
      ADDR_HI:   sfrRdData = dataHi;
      default:   sfrRdData = 8'h00;
    endcase
  end

  assign dacMode    = ctrlByte[5];
  assign convEnable = ctrlByte[4];
  assign irqFlag    = ctrlByte[7];
endmodule

// File: rtl/conv_front_chk.sv
module conv_front_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sfrWrEn,
  input logic       convStart,
  input logic       convDone,
  input logic       irqAck,
  input logic       irqFlag,
  input logic       convClkTick,
  input logic       convEnable,
  input logic [7:0] ctrlByte,
  input logic [2:0] activeSel
);
  AST_START_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> (ctrlByte[6] && convEnable)); // R3
  AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R8
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlByte[6] && convDone && convEnable && !sfrWrEn) |=> (!ctrlByte[6] && irqFlag)); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !(ctrlByte[6] && convDone)) |=> !irqFlag); // R5
  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !convEnable |-> (!convClkTick && !ctrlByte[6])); // R7
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlByte[6] && $past(ctrlByte[6])) |-> $stable(activeSel)); // R10
endmodule

bind conv_front conv_front_chk chk_i (
  .clk(clk), .rstN(rstN), .sfrWrEn(sfrWrEn), .convStart(convStart),
  .convDone(convDone), .irqAck(irqAck), .irqFlag(irqFlag),
  .convClkTick(convClkTick), .convEnable(convEnable),
  .ctrlByte(ctrlByte), .activeSel(stb.activeSel)
);

// File: tb/conv_front_tb_top.sv
`timescale 1ns/1ps
module conv_front_tb_top;
  localparam logic [7:0] A_CTRL = 8'hD9, A_LO = 8'hDC, A_HI = 8'hDD;

  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0] sfrAddr = 8'h00, sfrWrData = 8'h00, sfrRdData;
  logic sfrWrEn = 1'b0, irqAck = 1'b0, hwTrigMode = 1'b0, hwTrig = 1'b0;
  logic rcTick = 1'b0, rcEn = 1'b0, convStart, convClkTick, convDone = 1'b0;
  logic [9:0] convResult = '0, stubResult = '0;
  logic dacMode, convEnable, irqFlag;

  int checks = 0, errors = 0, cyc = 0, startCnt = 0, doneCnt = 0, stubCnt = 0, rcCnt = 0;
  bit stubBusy = 0, finished = 0;
  logic [15:0] expQ[$];

  always #2.5 clk = ~clk;

  conv_front dut_i (
    .clk(clk), .rstN(rstN), .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn),
    .sfrWrData(sfrWrData), .sfrRdData(sfrRdData), .irqAck(irqAck),
    .hwTrigMode(hwTrigMode), .hwTrig(hwTrig), .rcTick(rcTick),
    .convStart(convStart), .convClkTick(convClkTick), .convDone(convDone),
    .convResult(convResult), .dacMode(dacMode), .convEnable(convEnable),
    .irqFlag(irqFlag)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stub converter: 13 converter-clock ticks after the start strobe
  always @(posedge clk) begin
    cyc <= cyc + 1;
    convDone <= 1'b0;
    if (rstN && convStart) begin
      startCnt <= startCnt + 1;
      stubCnt <= 13; stubBusy <= 1'b1;
    end else if (stubBusy && convClkTick) begin
      if (stubCnt == 1) begin
        convDone <= 1'b1; convResult <= stubResult; stubBusy <= 1'b0;
      end
      stubCnt <= stubCnt - 1;
    end
  end

  // slow oscillator tick every 5 cycles
  always @(negedge clk) begin
    rcCnt <= (rcCnt == 4) ? 0 : rcCnt + 1;
    rcTick <= rcEn && (rcCnt == 4);
  end

  // monitor: pop expected result on each accepted completion
  always @(posedge clk) begin
    if (convDone && expQ.size() != 0) begin
      logic [15:0] exp;
      logic [7:0] lo, hi, c;
      exp = expQ.pop_front();
      @(negedge clk);
      sfrAddr = A_LO; #0.5 lo = sfrRdData;
      sfrAddr = A_HI; #0.5 hi = sfrRdData;
      sfrAddr = A_CTRL; #0.5 c = sfrRdData;
      check({hi, lo} == exp, "R6 result format", {hi, lo}, exp);
      check(c[7:6] == 2'b10, "R4 busy clear and flag set with capture", c[7:6], 2'b10);
      doneCnt++;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sfrAddr = a; sfrWrData = d; sfrWrEn = 1'b1;
    @(negedge clk); sfrWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    sfrAddr = a; #0.5 d = sfrRdData;
  endtask

  task automatic startConv(input logic [9:0] res, input logic [7:0] ctl, input logic [15:0] exp);
    stubResult = res;
    expQ.push_back(exp);
    wr(A_CTRL, ctl);
  endtask

  task automatic waitDone(input int n);
    while (doneCnt < n) @(negedge clk);
  endtask

  task automatic measure(output int p);
    int t0;
    do @(negedge clk); while (!convClkTick);
    t0 = cyc;
    do @(negedge clk); while (!convClkTick);
    p = cyc - t0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    if (!finished) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int p, s0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd(A_CTRL, v); check(v == 8'h00, "R1 ctrl reset", v, 8'h00);
    rd(A_LO, v);   check(v == 8'h00, "R1 low reset", v, 8'h00);
    rd(A_HI, v);   check(v == 8'h00, "R1 high reset", v, 8'h00);
    check(irqFlag == 1'b0, "R1 flag reset", irqFlag, 0);
    wr(A_CTRL, 8'h19);
    rd(A_CTRL, v); check(v == 8'h19, "R1 readback", v, 8'h19);
    rd(8'hDA, v);  check(v == 8'h00, "R1 unmapped address", v, 8'h00);

    // R7 go while disabled
    s0 = startCnt;
    wr(A_CTRL, 8'h41);
    p = 0;
    repeat (30) begin @(negedge clk); if (convClkTick) p++; end
    check(startCnt == s0, "R7 no start when disabled", startCnt, s0);
    check(p == 0, "R7 no ticks when disabled", p, 0);
    rd(A_CTRL, v); check(v[6] == 1'b0, "R7 busy stays 0", v[6], 0);

    // R2 prescaler periods
    for (int k = 1; k < 8; k++) begin
      wr(A_CTRL, 8'h10 | 8'(k));
      measure(p);
      check(p == (1 << k), "R2 divider period", p, 1 << k);
    end
    rcEn = 1'b1;
    wr(A_CTRL, 8'h10);
    measure(p);
    check(p == 5, "R2 select 0 follows rcTick", p, 5);
    rcEn = 1'b0;

    // R12 pins
    wr(A_CTRL, 8'h31);
    check(dacMode && convEnable, "R12 dacMode/convEnable", {dacMode, convEnable}, 2'b11);
    wr(A_CTRL, 8'h11);
    check(!dacMode && convEnable, "R12 dacMode cleared", {dacMode, convEnable}, 2'b01);

    // R3/R6 right-adjusted negative
    s0 = startCnt;
    startConv(10'h3F0, 8'h51, 16'hFFF0);
    rd(A_CTRL, v); check(v[6] == 1'b1, "R3 busy after go", v[6], 1);
    repeat (3) @(negedge clk);
    check(startCnt == s0 + 1, "R3 single start strobe", startCnt, s0 + 1);
    waitDone(1);
    check(irqFlag == 1'b1, "R4 flag raised", irqFlag, 1);
    // R5 acknowledge
    @(negedge clk); irqAck = 1'b1; @(negedge clk); irqAck = 1'b0;
    check(irqFlag == 1'b0, "R5 ack clears flag", irqFlag, 0);

    // R6 left-adjusted positive, right-adjusted positive
    startConv(10'h155, 8'h59, 16'h5540);
    waitDone(2);
    startConv(10'h0AB, 8'h51, 16'h00AB);
    waitDone(3);

    // R8 go while busy, write of 0 to go
    s0 = startCnt;
    startConv(10'h201, 8'h51, 16'hFE01);
    wr(A_CTRL, 8'h51);
    wr(A_CTRL, 8'h11);
    rd(A_CTRL, v); check(v[6] == 1'b1, "R8 still busy after go=0 write", v[6], 1);
    waitDone(4);
    check(startCnt == s0 + 1, "R8 no second start", startCnt, s0 + 1);

    // R10 clock select change deferred
    startConv(10'h07F, 8'h51, 16'h007F);
    wr(A_CTRL, 8'h14);
    measure(p);
    check(p == 2, "R10 old divider during conversion", p, 2);
    waitDone(5);
    repeat (2) @(negedge clk);
    measure(p);
    check(p == 16, "R10 new divider after conversion", p, 16);

    // R9 hardware trigger mode
    wr(A_CTRL, 8'h11);
    hwTrigMode = 1'b1;
    s0 = startCnt;
    wr(A_CTRL, 8'h51);
    repeat (5) @(negedge clk);
    check(startCnt == s0, "R9 software go ignored", startCnt, s0);
    stubResult = 10'h2AA;
    expQ.push_back(16'hFEAA);
    @(negedge clk); hwTrig = 1'b1; @(negedge clk); hwTrig = 1'b0;
    rd(A_CTRL, v); check(v[6] == 1'b1, "R9 busy from hardware start", v[6], 1);
    waitDone(6);
    hwTrigMode = 1'b0;

    // R11 abort by disable
    @(negedge clk); irqAck = 1'b1; @(negedge clk); irqAck = 1'b0;
    stubResult = 10'h001;
    wr(A_CTRL, 8'h51);
    wr(A_CTRL, 8'h01);
    rd(A_CTRL, v); check(v[7:6] == 2'b00, "R11 abort clears busy, no flag", v[7:6], 0);
    repeat (40) @(negedge clk);
    check(irqFlag == 1'b0, "R11 no flag after abort", irqFlag, 0);
    rd(A_LO, v); check(v == 8'hAA, "R11 result kept", v, 8'hAA);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule